// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches 32 general-purpose input pins and turns activity on them into interrupt requests. Every pin passes through a two-stage synchroniser. It is then judged either by its level or by its edges, and the judgement is recorded in a per-pin status bit. Each pin has its own settings for mode, polarity, latching and edge selection.

Software reaches the block through a simple 16-bit register port. Pins 0 to 15 form the low half and pins 16 to 31 form the high half. For every function, the high-half register sits two bytes above the low-half one. Status bits are cleared by writing ones.

A status bit that is also enabled makes its pin pending. Any pending pin raises the single interrupt line. A read-only register names the lowest-numbered pending pin, so an interrupt handler can dispatch with one read.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every status, enable and configuration bit reads 0, so every pin is in level mode. `irq_o` is 0 and the pending-index register reads 0x0000.
- R2: The configuration registers are read/write and read back exactly what was last written. The low-half addresses are 0x0C (enable), 0x10 (mode, 1 = edge), 0x14 (polarity, 1 = active-high), 0x18 (hold), 0x20 (falling select) and 0x24 (rising select). The high-half copy of each is at the low-half address + 2. Status is at 0x08 and 0x0A, and the pending index is at 0x28.
- R3: In level mode, a pin's status bit equals 1 whenever the synchronised pin matches its polarity bit. The status bit follows a pin change on the third rising clock edge after that change. Writing 1 to the status bit does not hold it at 0 while the pin stays active.
- R4: In edge mode with the hold bit at 1, a selected edge sets the status bit and the bit stays set. Rising edges count only when the rising-select bit is 1, and falling edges count only when the falling-select bit is 1.
- R5: Writing 1 to a latched status bit clears it. Writing 0 leaves it unchanged. If an edge event and a clear arrive in the same cycle, the event wins.
- R6: In edge mode with the hold bit at 0, each selected edge makes the status bit 1 for exactly one clock cycle, even while the pin stays at its new level.
- R7: With both select bits at 1, rising and falling edges each set status. With both select bits at 0, no edge sets status.
- R8: `irq_o` is the OR over all pins of status AND enable. A set status bit whose enable bit is 0 does not raise `irq_o`.
- R9: The pending-index register at 0x28 returns bit 15 = 1 when any pin is pending, with bits 4:0 holding the lowest-numbered pending pin. Any pending low-half pin therefore wins over every pending high-half pin. The register returns 0x0000 when no pin is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous GPIO inputs |
| bus_wr_i | input | 1 | Register write strobe, applied on the rising edge |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong polarity, mode or select bit shows up at the status register on the third edge after the pin moves. A status bit stuck at 1 in through mode shows up one cycle later, as a pulse that fails to end. A broken clear shows up as a latched bit that survives a write of ones. An enable or priority fault is visible at once on `irq_o` and in the pending-index word, in the same cycle that the status or enable register changes.

// File: rtl/gid_pkg.sv
package gid_pkg;

   // indices of the per-pin configuration planes
   localparam int NCFG    = 6;
   localparam int CF_EN   = 0;
   localparam int CF_TYPE = 1;
   localparam int CF_LVL  = 2;
   localparam int CF_HOLD = 3;
   localparam int CF_FALL = 4;
   localparam int CF_RISE = 5;

   // byte offsets of the low-half registers; high half sits HALF_STEP above
   localparam logic [7:0] OFS_STAT  = 8'h08;
   localparam logic [7:0] OFS_PEND  = 8'h28;
   localparam logic [7:0] HALF_STEP = 8'h02;

   function automatic logic [7:0] cfg_base(int c);
      case (c)
         CF_EN:   return 8'h0C;
         CF_TYPE: return 8'h10;
         CF_LVL:  return 8'h14;
         CF_HOLD: return 8'h18;
         CF_FALL: return 8'h20;
         CF_RISE: return 8'h24;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
   parameter int   W       = 32,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gid_sync needs at least two stages");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= {W{RST_VAL}};
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gid_pin_cell.sv
module gid_pin_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_s_i,
   input  logic edge_mode_i,
   input  logic act_high_i,
   input  logic hold_i,
   input  logic fall_en_i,
   input  logic rise_en_i,
   input  logic clr_i,
   output logic stat_o
);

   logic prev_q, stat_q;
   logic rise, fall, evt, lvl_act, stat_d;

   assign rise    = pin_s_i & ~prev_q;
   assign fall    = ~pin_s_i & prev_q;
   assign evt     = (rise & rise_en_i) | (fall & fall_en_i);
   assign lvl_act = (pin_s_i == act_high_i);

   always_comb begin
      if (!edge_mode_i)  stat_d = lvl_act;
      else if (hold_i)   stat_d = evt | (stat_q & ~clr_i);
      else               stat_d = evt;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b1;
         stat_q <= 1'b0;
      end else begin
         prev_q <= pin_s_i;
         stat_q <= stat_d;
      end
   end

   assign stat_o = stat_q;

   // R5
   hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && hold_i && stat_q && !clr_i && !evt) |=> stat_q);

   // R5
   w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && hold_i && clr_i && !evt) |=> !stat_q);

   // R6
   through_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && !hold_i && !evt) |=> !stat_q);

endmodule

// File: rtl/gid_first_set.sv
module gid_first_set #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = W-1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign valid_o = |vec_i;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gid_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int REG_W  = 16,
   parameter int ADDR_W = 6,
   parameter int SYNC_N = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NPINS-1:0]  pin_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   output logic              irq_o
);

   localparam int NHALF = NPINS / REG_W;
   localparam int IDX_W = $clog2(NPINS);

   if (NHALF * REG_W != NPINS || NHALF != 2) begin : g_bad_split
      $error("NPINS must be exactly two register widths");
   end
   if (IDX_W >= REG_W) begin : g_bad_idx
      $error("pin index does not fit beside the valid flag");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("address too narrow for the register map");
   end

   function automatic logic [ADDR_W-1:0] reg_addr(logic [7:0] base, int h);
      return ADDR_W'(base + HALF_STEP * 8'(h));
   endfunction

   // configuration planes
   logic [NPINS-1:0] cfg_q [NCFG];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int c = 0; c < NCFG; c++) cfg_q[c] <= '0;
      end else if (bus_wr_i) begin
         for (int c = 0; c < NCFG; c++)
            for (int h = 0; h < NHALF; h++)
               if (bus_addr_i == reg_addr(cfg_base(c), h))
                  cfg_q[c][h*REG_W +: REG_W] <= bus_wdata_i;
      end
   end

   // write-one-to-clear strobes
   logic [NPINS-1:0] clr;
   always_comb begin
      clr = '0;
      for (int h = 0; h < NHALF; h++)
         if (bus_wr_i && bus_addr_i == reg_addr(OFS_STAT, h))
            clr[h*REG_W +: REG_W] = bus_wdata_i;
   end

   logic [NPINS-1:0] pin_s, stat, pend;

   gid_sync #(.W(NPINS), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gid_pin_cell u_cell (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .pin_s_i    (pin_s[p]),
         .edge_mode_i(cfg_q[CF_TYPE][p]),
         .act_high_i (cfg_q[CF_LVL][p]),
         .hold_i     (cfg_q[CF_HOLD][p]),
         .fall_en_i  (cfg_q[CF_FALL][p]),
         .rise_en_i  (cfg_q[CF_RISE][p]),
         .clr_i      (clr[p]),
         .stat_o     (stat[p])
      );
   end

   assign pend  = stat & cfg_q[CF_EN];
   assign irq_o = |pend;

   logic             idx_valid;
   logic [IDX_W-1:0] idx;

   gid_first_set #(.W(NPINS), .IDX_W(IDX_W)) u_first (
      .vec_i  (pend),
      .valid_o(idx_valid),
      .idx_o  (idx)
   );

   // read mux
   always_comb begin
      bus_rdata_o = '0;
      for (int h = 0; h < NHALF; h++)
         if (bus_addr_i == reg_addr(OFS_STAT, h))
            bus_rdata_o = stat[h*REG_W +: REG_W];
      for (int c = 0; c < NCFG; c++)
         for (int h = 0; h < NHALF; h++)
            if (bus_addr_i == reg_addr(cfg_base(c), h))
               bus_rdata_o = cfg_q[c][h*REG_W +: REG_W];
      if (bus_addr_i == reg_addr(OFS_PEND, 0)) begin
         bus_rdata_o[REG_W-1]   = idx_valid;
         bus_rdata_o[IDX_W-1:0] = idx;
      end
   end

   logic [NPINS-1:0] below_mask;
   assign below_mask = (NPINS'(1) << idx) - NPINS'(1);

   // R9
   prio_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idx_valid |-> (pend[idx] && ((pend & below_mask) == '0)));

   // R8
   irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && bus_addr_i == reg_addr(OFS_PEND, 0)) |-> bus_rdata_o[REG_W-1]);

endmodule

// File: tb/gpio_irq_detect_bench.sv
`timescale 1ns/100ps
module gpio_irq_detect_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '1;
   logic        wr = 1'b0;
   logic [5:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_detect u_gpio_irq_detect (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pin_i      (pins),
      .bus_wr_i   (wr),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_o      (irq)
   );

   // row: [8]edge [7]act_high [6]hold [5]fall [4]rise [3]pin_before [2]pin_after [1]stat_t3 [0]stat_t4
   localparam logic [8:0] TBL [10] = '{
      9'b0_1_0_0_0_0_1_1_1,   // R3 level active-high, pin rises
      9'b0_0_0_0_0_1_0_1_1,   // R3 level active-low, pin falls
      9'b0_1_0_0_0_1_0_0_0,   // R3 level active-high, pin falls
      9'b1_0_1_0_1_0_1_1_1,   // R4 hold, rising select, rising edge
      9'b1_0_1_0_1_1_0_0_0,   // R4 hold, rising select, falling edge
      9'b1_0_1_1_0_1_0_1_1,   // R4 hold, falling select, falling edge
      9'b1_0_0_0_1_0_1_1_0,   // R6 through, rising edge gives one-cycle pulse
      9'b1_0_0_1_1_1_0_1_0,   // R7 through, both edges, falling edge
      9'b1_0_1_1_1_0_1_1_1,   // R7 hold, both edges, rising edge
      9'b1_0_1_0_0_0_1_0_0    // R7 hold, no edge selected
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [5:0] a, output logic [15:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pins = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   localparam logic [5:0] CFG_ADDR [6] = '{6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};

   initial begin
      logic [15:0] v;
      do_reset();

      // R1 reset state
      for (int h = 0; h < 2; h++) begin
         rd_reg(6'h08 + 6'(2*h), v); chk("R1 status", v, 16'h0000);
         for (int c = 0; c < 6; c++) begin
            rd_reg(CFG_ADDR[c] + 6'(2*h), v); chk("R1 config", v, 16'h0000);
         end
      end
      rd_reg(6'h28, v); chk("R1 pend index", v, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'h0000);

      // R2 read-back with distinct patterns
      for (int c = 0; c < 6; c++)
         for (int h = 0; h < 2; h++)
            wr_reg(CFG_ADDR[c] + 6'(2*h), 16'h1111 * 16'(c + 1) ^ 16'(h * 16'h8421));
      for (int c = 0; c < 6; c++)
         for (int h = 0; h < 2; h++) begin
            rd_reg(CFG_ADDR[c] + 6'(2*h), v);
            chk("R2 readback", v, 16'h1111 * 16'(c + 1) ^ 16'(h * 16'h8421));
         end

      // table walk on pin 0
      for (int r = 0; r < 10; r++) begin
         logic [8:0] t;
         t = TBL[r];
         do_reset();
         pins[0] = t[3];
         wait_n(4);
         wr_reg(6'h10, {15'd0, t[8]});
         wr_reg(6'h14, {15'd0, t[7]});
         wr_reg(6'h18, {15'd0, t[6]});
         wr_reg(6'h20, {15'd0, t[5]});
         wr_reg(6'h24, {15'd0, t[4]});
         wr_reg(6'h08, 16'hFFFF);
         pins[0] = t[2];
         wait_n(3);
         rd_reg(6'h08, v);
         chk($sformatf("R%0d table row %0d third edge", (r < 3) ? 3 : (r < 6) ? 4 : (r == 6) ? 6 : 7, r),
             {15'd0, v[0]}, {15'd0, t[1]});
         wait_n(1);
         rd_reg(6'h08, v);
         chk($sformatf("R%0d table row %0d next cycle", (r < 3) ? 3 : (r < 6) ? 4 : (r == 6) ? 6 : 7, r),
             {15'd0, v[0]}, {15'd0, t[0]});
      end

      // R3 level: write-one does not hold status low while active
      do_reset();
      wr_reg(6'h14, 16'h0001);      // active-high, pin 0 is high
      wait_n(1);
      wr_reg(6'h08, 16'h0001);
      rd_reg(6'h08, v); chk("R3 level ignores clear", v & 16'h0001, 16'h0001);

      // R5 write-one-to-clear on pin 3, hold mode rising
      do_reset();
      pins[3] = 1'b0; wait_n(4);
      wr_reg(6'h10, 16'h0008); wr_reg(6'h18, 16'h0008); wr_reg(6'h24, 16'h0008);
      wr_reg(6'h08, 16'hFFFF);
      pins[3] = 1'b1; wait_n(4);
      rd_reg(6'h08, v); chk("R5 latched", v, 16'h0008);
      wr_reg(6'h08, 16'h0000);
      rd_reg(6'h08, v); chk("R5 write zero keeps", v, 16'h0008);
      wr_reg(6'h08, 16'hFFF7);
      rd_reg(6'h08, v); chk("R5 other bits keep", v, 16'h0008);
      wr_reg(6'h08, 16'h0008);
      rd_reg(6'h08, v); chk("R5 write one clears", v, 16'h0000);

      // R8 / R9 on pin 20 (high half bit 4) and pin 5
      do_reset();
      pins[20] = 1'b0; pins[5] = 1'b0; wait_n(4);
      wr_reg(6'h12, 16'h0010); wr_reg(6'h1A, 16'h0010); wr_reg(6'h26, 16'h0010);
      wr_reg(6'h10, 16'h0020); wr_reg(6'h18, 16'h0020); wr_reg(6'h24, 16'h0020);
      wr_reg(6'h08, 16'hFFFF); wr_reg(6'h0A, 16'hFFFF);
      pins[20] = 1'b1; wait_n(4);
      rd_reg(6'h0A, v); chk("R8 high status set", v, 16'h0010);
      chk("R8 disabled no irq", {15'd0, irq}, 16'h0000);
      rd_reg(6'h28, v); chk("R9 none pending", v, 16'h0000);
      wr_reg(6'h0E, 16'h0010);
      chk("R8 enabled irq", {15'd0, irq}, 16'h0001);
      rd_reg(6'h28, v); chk("R9 index 20", v, 16'h8014);
      pins[5] = 1'b1; wait_n(4);
      wr_reg(6'h0C, 16'h0020);
      rd_reg(6'h28, v); chk("R9 low half wins", v, 16'h8005);
      wr_reg(6'h08, 16'h0020);
      rd_reg(6'h28, v); chk("R9 back to 20", v, 16'h8014);
      wr_reg(6'h0A, 16'h0010);
      chk("R8 irq drops", {15'd0, irq}, 16'h0000);
      rd_reg(6'h28, v); chk("R9 empty", v, 16'h0000);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule